// File: doc/BRIEF.md
# Dual-Squarer Modular Exponentiator with Lookahead Queue

This block computes m^d mod n by scanning the exponent from its least significant bit upward and building every product from squarings alone. A product a·b is taken as ((a+b)² − (a−b)²)/4 mod n, and the divide by four is done as two modular halvings. Two identical iterative modular squarers run side by side. Each parallel use of the pair is one "slot".

On a 1 bit the block needs two squares for the product. Whenever that leaves a squarer idle, the spare unit computes future powers of the base ahead of time. These precomputed powers sit in a queue of EXTRAMAX + 2 entries, whose head always holds the current base power b. A counter records how many powers are ready ahead of the head. It bounds the lookahead and selects one of four schedules for each exponent bit.

A caller presents m, d and an odd modulus n and pulses `start`. When `done` rises, `result` and `slot_count` are valid and stay valid until the next accepted start. `slot_count` gives the number of slots spent.

Top module: `sqx_exp_engine`

## Requirements
- R1: After reset `done` is 0 and `slot_count` is 0.
- R2: The lookahead counter never exceeds EXTRAMAX. It rises by one on a 1 bit taken while below EXTRAMAX and falls by one on every other bit that finds it above zero.
- R3: For 0 ≤ m < n and an odd n ≥ 3, `result` equals m^d mod n once `done` is high. All EXP_W bits of d are processed, with bit 0 first.
- R4: A 1 bit taken while the counter is below EXTRAMAX costs two slots. Both slots start both squarers together. The second squarer extends the queue by two squarings, and the counter then rises by one.
- R5: A 1 bit taken while the counter equals EXTRAMAX costs one slot. That slot squares the sum and the difference at once, and the counter then falls by one.
- R6: A 0 bit taken while the counter is 0 costs one slot, which uses only the first squarer to square the queue head in place.
- R7: A 0 bit taken while the counter is above 0 costs no slot. The queue only advances.
- R8: `slot_count` equals the sum of the per-bit slot costs in R4 to R7. `done` is low while a computation runs. `done` and `result` hold steady after completion until a new start.
- R9: A `start` pulse that arrives while a computation is running is ignored, and the running computation completes with its original operands.
- R10: Every squarer output and every value of the accumulator after start is fully reduced, that is, below n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation, accepted only when idle or done |
| base_m | input | WIDTH | Base, must be below modulus_n |
| exp_d | input | EXP_W | Exponent |
| modulus_n | input | WIDTH | Odd modulus, at least 3 |
| result | output | WIDTH | m^d mod n, valid while done is high |
| done | output | 1 | Computation complete |
| slot_count | output | CNT_W | Number of squarer slots spent |

## Verification
The assertions check, on every cycle, the following properties:
- the lookahead counter stays within its bound;
- every squarer output and the accumulator stay below n;
- a paired slot occupies both squarers while an in-place base square occupies only the first;
- a queue-only step leaves the slot count unchanged;
- the outputs stay frozen after completion.

Only the directed scenarios can show that the arithmetic is right, by comparing the result with a reference exponentiation. They also check that the total slot count matches a model of the four schedules over exponent patterns chosen to drive the counter up to its ceiling and back down. A further scenario shows that a start pulse arriving mid-run is ignored.

// File: rtl/sqx_pkg.sv
// Shared types for the dual-squarer exponentiator.
package sqx_pkg;
    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_LAUNCH,
        ST_WAIT,
        ST_COMBINE,
        ST_DONE
    } sqx_state_e;

    // Per-bit schedule chosen from the exponent bit and the lookahead counter.
    typedef enum logic [1:0] {
        OP_GROW,   // 1 bit, counter below limit: two slots, queue grows
        OP_FULL,   // 1 bit, counter at limit: one slot with both squares
        OP_SQR,    // 0 bit, counter zero: square the head in place
        OP_SKIP    // 0 bit, counter above zero: no slot
    } sqx_op_e;
endpackage

// File: rtl/sqx_modsq.sv
// Iterative modular squarer: y = x*x mod n, one multiplier bit per cycle,
// MSB first (double-and-add with reduction after each step).
// Assumes x < n and n < 2**W. Latency W cycles from start to done.
// The start input must not be pulsed while busy.
module sqx_modsq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] x,
    input  logic [W-1:0] n,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] y
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  x_q, n_q, acc;
    logic [CW-1:0] idx;
    logic [W:0]    dbl, red1, addv, red2, n_ext;

    // One double-and-add step with two conditional subtractions.
    always_comb begin
        n_ext = {1'b0, n_q};
        dbl   = {acc, 1'b0};
        red1  = (dbl >= n_ext) ? dbl - n_ext : dbl;
        addv  = red1 + (x_q[idx] ? {1'b0, x_q} : '0);
        red2  = (addv >= n_ext) ? addv - n_ext : addv;
    end

    // Sequencer: load operands on start, step through multiplier bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q  <= '0;
            n_q  <= '0;
            acc  <= '0;
            idx  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            y    <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                x_q  <= x;
                n_q  <= n;
                acc  <= '0;
                idx  <= CW'(W - 1);
                busy <= 1'b1;
            end else if (busy) begin
                acc <= red2[W-1:0];
                if (idx == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    y    <= red2[W-1:0];
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    AST_SQ_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (y < n_q)); // R10
    AST_SQ_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R4
endmodule

// File: rtl/sqx_addsub.sv
// Modular sum and difference of two reduced operands.
// Assumes a < n and b < n.
module sqx_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff
);
    logic [W:0] raw;

    // Sum with one conditional subtraction; difference wrapped through n.
    always_comb begin
        raw  = {1'b0, a} + {1'b0, b};
        sum  = (raw >= {1'b0, n}) ? W'(raw - {1'b0, n}) : raw[W-1:0];
        diff = (a >= b) ? a - b : (n - b) + a;
    end
endmodule

// File: rtl/sqx_combine.sv
// Forms (sq_hi - sq_lo)/4 mod n as a modular subtraction followed by two
// modular halvings. Assumes both squares < n and n odd.
module sqx_combine #(
    parameter int W      = 16,
    parameter int HALVES = 2
) (
    input  logic [W-1:0] sq_hi,
    input  logic [W-1:0] sq_lo,
    input  logic [W-1:0] n,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [0:HALVES];

    // Modular subtraction feeding the halving chain.
    always_comb begin
        stage[0] = (sq_hi >= sq_lo) ? sq_hi - sq_lo : (n - sq_lo) + sq_hi;
    end

    // Each halving adds n first when the value is odd.
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        logic [W:0] odd_sum;
        assign odd_sum    = {1'b0, stage[g]} + {1'b0, n};
        assign stage[g+1] = stage[g][0] ? odd_sum[W:1] : {1'b0, stage[g][W-1:1]};
    end

    assign q = stage[HALVES];
endmodule

// File: rtl/sqx_exp_engine.sv
// Right-to-left modular exponentiator using only squarings on two parallel
// squarers. A queue of precomputed base powers (head = current base power)
// fills idle squarer slots; a counter bounded by EXTRAMAX picks the schedule.
// Assumes base_m < modulus_n, modulus_n odd and >= 3, EXTRAMAX >= 1.
module sqx_exp_engine #(
    parameter int WIDTH    = 16,
    parameter int EXP_W    = 16,
    parameter int EXTRAMAX = 2,
    parameter int CNT_W    = $clog2(2 * EXP_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] base_m,
    input  logic [EXP_W-1:0] exp_d,
    input  logic [WIDTH-1:0] modulus_n,
    output logic [WIDTH-1:0] result,
    output logic             done,
    output logic [CNT_W-1:0] slot_count
);
    import sqx_pkg::*;

    localparam int QD   = EXTRAMAX + 2;
    localparam int QI_W = $clog2(QD);
    localparam int EXW  = $clog2(EXTRAMAX + 1);
    localparam int BW   = $clog2(EXP_W + 1);

    sqx_state_e       state_q;
    sqx_op_e          op_q, op_next;
    logic             phase_q;
    logic [WIDTH-1:0] a_q, n_q, tmp_lo, tmp_hi;
    logic [WIDTH-1:0] q_r [0:QD-1];
    logic [EXP_W-1:0] d_sh;
    logic [EXW-1:0]   extra_q;
    logic [BW-1:0]    bit_cnt;
    logic [CNT_W-1:0] slot_q;

    logic [WIDTH-1:0] ab_sum, ab_diff, comb_q;
    logic [QI_W-1:0]  src_idx, dst_idx;
    logic [1:0]             sq_go, sq_busy, sq_done;
    logic [1:0][WIDTH-1:0]  sq_x, sq_y;
    logic             last_bit, slot_end;

    // Sum and difference of accumulator and queue head.
    sqx_addsub #(.W(WIDTH)) u_addsub (
        .a(a_q), .b(q_r[0]), .n(n_q), .sum(ab_sum), .diff(ab_diff)
    );

    // Product recovery from the two squares.
    sqx_combine #(.W(WIDTH), .HALVES(2)) u_comb (
        .sq_hi(tmp_hi), .sq_lo(tmp_lo), .n(n_q), .q(comb_q)
    );

    // Two identical squarers.
    for (genvar g = 0; g < 2; g++) begin : g_sq
        sqx_modsq #(.W(WIDTH)) u_sq (
            .clk(clk), .rst_n(rst_n), .start(sq_go[g]), .x(sq_x[g]),
            .n(n_q), .busy(sq_busy[g]), .done(sq_done[g]), .y(sq_y[g])
        );
    end

    // Schedule choice for the current exponent bit.
    always_comb begin
        if (d_sh[0]) op_next = (extra_q == EXW'(EXTRAMAX)) ? OP_FULL : OP_GROW;
        else         op_next = (extra_q == '0) ? OP_SQR : OP_SKIP;
        last_bit = (bit_cnt == BW'(EXP_W));
    end

    // Queue indices for the lookahead squaring of the current phase.
    always_comb begin
        src_idx = QI_W'(extra_q) + QI_W'(phase_q);
        dst_idx = src_idx + 1'b1;
    end

    // Squarer operands and launch strobes.
    always_comb begin
        sq_go = 2'b00;
        sq_x[0] = ab_diff;
        sq_x[1] = ab_sum;
        unique case (op_q)
            OP_GROW: begin
                sq_x[0] = phase_q ? ab_sum : ab_diff;
                sq_x[1] = q_r[src_idx];
            end
            OP_SQR:  sq_x[0] = q_r[0];
            default: ;
        endcase
        if (state_q == ST_LAUNCH) sq_go = (op_q == OP_SQR) ? 2'b01 : 2'b11;
        slot_end = (state_q == ST_WAIT) && sq_done[0] &&
                   (sq_done[1] || op_q == OP_SQR);
    end

    // Main controller: accept start, walk exponent bits, run slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_SQR;
            phase_q <= 1'b0;
            a_q     <= '0;
            n_q     <= '0;
            tmp_lo  <= '0;
            tmp_hi  <= '0;
            d_sh    <= '0;
            extra_q <= '0;
            bit_cnt <= '0;
            slot_q  <= '0;
            for (int i = 0; i < QD; i++) q_r[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        n_q     <= modulus_n;
                        d_sh    <= exp_d;
                        a_q     <= WIDTH'(1);
                        extra_q <= '0;
                        bit_cnt <= '0;
                        slot_q  <= '0;
                        phase_q <= 1'b0;
                        q_r[0]  <= base_m;
                        for (int i = 1; i < QD; i++) q_r[i] <= '0;
                        state_q <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    phase_q <= 1'b0;
                    op_q    <= op_next;
                    if (last_bit) begin
                        state_q <= ST_DONE;
                    end else if (op_next == OP_SKIP) begin
                        for (int i = 0; i < QD - 1; i++) q_r[i] <= q_r[i+1];
                        extra_q <= extra_q - 1'b1;
                        d_sh    <= d_sh >> 1;
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        state_q <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    slot_q  <= slot_q + 1'b1;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (slot_end) begin
                        unique case (op_q)
                            OP_GROW: begin
                                q_r[dst_idx] <= sq_y[1];
                                if (!phase_q) begin
                                    tmp_lo  <= sq_y[0];
                                    phase_q <= 1'b1;
                                    state_q <= ST_LAUNCH;
                                end else begin
                                    tmp_hi  <= sq_y[0];
                                    state_q <= ST_COMBINE;
                                end
                            end
                            OP_FULL: begin
                                tmp_lo  <= sq_y[0];
                                tmp_hi  <= sq_y[1];
                                state_q <= ST_COMBINE;
                            end
                            default: begin
                                q_r[0]  <= sq_y[0];
                                d_sh    <= d_sh >> 1;
                                bit_cnt <= bit_cnt + 1'b1;
                                state_q <= ST_DECIDE;
                            end
                        endcase
                    end
                end
                ST_COMBINE: begin
                    a_q <= comb_q;
                    for (int i = 0; i < QD - 1; i++) q_r[i] <= q_r[i+1];
                    extra_q <= (op_q == OP_GROW) ? extra_q + 1'b1 : extra_q - 1'b1;
                    d_sh    <= d_sh >> 1;
                    bit_cnt <= bit_cnt + 1'b1;
                    state_q <= ST_DECIDE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign result     = a_q;
    assign done       = (state_q == ST_DONE);
    assign slot_count = slot_q;

    AST_EXTRA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        extra_q <= EXW'(EXTRAMAX)); // R2
    AST_ACC_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (a_q < n_q)); // R10
    AST_PAIR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAUNCH && op_q != OP_SQR) |=> (sq_busy == 2'b11)); // R4
    AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAUNCH && op_q == OP_SQR) |=> (sq_busy == 2'b01)); // R6
    AST_SKIP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !last_bit && op_next == OP_SKIP)
        |=> $stable(slot_count)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result) && $stable(slot_count))); // R8
endmodule

// File: tb/tb_sqx_exp_engine.sv
module tb_sqx_exp_engine;
    localparam int W  = 16;
    localparam int E  = 16;
    localparam int EM = 2;
    localparam int CW = $clog2(2 * E + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  base_m = '0;
    logic [E-1:0]  exp_d = '0;
    logic [W-1:0]  modulus_n = '0;
    logic [W-1:0]  result;
    logic          done;
    logic [CW-1:0] slot_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    sqx_exp_engine #(.WIDTH(W), .EXP_W(E), .EXTRAMAX(EM), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_m(base_m),
        .exp_d(exp_d), .modulus_n(modulus_n), .result(result),
        .done(done), .slot_count(slot_count)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_pow(input longint m, input longint d, input longint n);
        longint r = 1, b = m;
        for (int i = 0; i < E; i++) begin
            if (d[i]) r = (r * b) % n;
            b = (b * b) % n;
        end
        return r % n;
    endfunction

    function automatic int ref_slots(input longint d);
        int e = 0, s = 0;
        for (int i = 0; i < E; i++) begin
            if (d[i]) begin
                if (e < EM) begin s += 2; e++; end
                else begin s += 1; e--; end
            end else if (e == 0) s += 1;
            else e--;
        end
        return s;
    endfunction

    task automatic launch(input logic [W-1:0] m, input logic [E-1:0] d, input logic [W-1:0] n);
        @(negedge clk);
        base_m = m; exp_d = d; modulus_n = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_and_check(input logic [W-1:0] m, input logic [E-1:0] d,
                                    input logic [W-1:0] n, input string slot_req);
        longint er = ref_pow(m, d, n);
        int     es = ref_slots(d);
        while (!done) @(negedge clk);
        chk(result == W'(er), "R3 result", result, er);
        chk(result < n, "R10 result reduced", result, n - 1);
        chk(slot_count == CW'(es), slot_req, slot_count, es);
        repeat (3) @(negedge clk);
        chk(done && result == W'(er), "R8 outputs held", result, er);
    endtask

    task automatic run_case(input logic [W-1:0] m, input logic [E-1:0] d,
                            input logic [W-1:0] n, input string slot_req);
        launch(m, d, n);
        chk(done == 1'b0, "R8 done low while running", done, 0);
        finish_and_check(m, d, n, slot_req);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(slot_count == '0, "R1 slot_count after reset", slot_count, 0);
    endtask

    task automatic t_zero_exp();
        run_case(16'd1234, '0, 16'd40961, "R6 slots for all-zero exponent");
    endtask

    task automatic t_mixed_exp();
        run_case(16'd7, 16'h000C, 16'd1009, "R4 R7 slots for 0b01100");
    endtask

    task automatic t_all_ones();
        run_case(16'd12345, 16'hFFFF, 16'd65521, "R4 R5 R2 slots for all-ones");
    endtask

    task automatic t_edge_base();
        run_case(16'd65520, 16'h0001, 16'd65521, "R4 R7 slots for single low bit");
        run_case(16'd0, 16'hA5C3, 16'd257, "R8 slots zero base");
        run_case(16'd2, 16'h8001, 16'd3, "R8 slots small modulus");
        run_case(16'd54321, 16'h6DB7, 16'd60001, "R8 slots mixed pattern");
    endtask

    task automatic t_ignore_start();
        launch(16'd321, 16'h3C5A, 16'd49999);
        repeat (40) @(negedge clk);
        base_m = 16'd5; exp_d = 16'h0001; modulus_n = 16'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R9 run continues after mid-run start", done, 0);
        finish_and_check(16'd321, 16'h3C5A, 16'd49999, "R9 slots unchanged by mid-run start");
    endtask

    initial begin
        t_reset();
        t_zero_exp();
        t_mixed_exp();
        t_all_ones();
        t_edge_base();
        t_ignore_start();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule